// File: doc/BRIEF.md
# Multicycle Accumulator Processor

This block is a small accumulator machine. It has a 16-bit two's-complement data word and a private 4096-word memory addressed by word. Every instruction is one 16-bit word. The operation code sits in bits 15:12 and a 12-bit operand address in bits 11:0. Inside the block, the program counter, memory address latch, memory data latch, instruction latch, accumulator and two 8-bit I/O latches exchange values over one shared bus. Each cycle, a 3-bit source code picks what drives the bus and a 3-bit destination code picks which register captures it.

A one-hot step counter with seven positions sequences the work. Positions 0 and 1 fetch the instruction: the address latch takes the program counter, then the instruction latch takes the memory word while the program counter advances by one. Later positions carry out the operation. Control is a fixed decode of the operation code and the current position. For each position it gives a bus source, a bus destination, a 2-bit arithmetic code (pass, add, subtract, zero) and an early-return flag. The early-return flag sends the counter back to position 0 at the next edge.

Software is loaded through a write port while reset is held. The input latch samples the input pins on every cycle, and the program reads it by polling. The machine runs until it executes the stop instruction.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pc`, `acc` and `out_byte` are 0 and `halted` is 0.
- R2: Each fetch reads the word at `pc` and increments `pc` by one, wrapping at 12 bits.
- R3: Opcode 1 (load) copies memory word X into the accumulator, and opcode 2 (store) writes the accumulator into word X.
- R4: Opcode 3 adds word X to the accumulator and opcode 4 subtracts it, both modulo 2^16.
- R5: Opcode 10 (clear) sets the accumulator to zero.
- R6: Opcode 8 (skip) reads bits 11:10 and then increments `pc` once more when the condition holds. The codes are 00 for accumulator negative, 01 for accumulator zero and 10 for accumulator positive and non-zero. Code 11 never skips.
- R7: Opcode 9 (jump) loads `pc` with X.
- R8: The indirect forms first read a pointer P from word X. Opcode 13 loads word P, opcode 11 adds word P, opcode 14 stores the accumulator to word P, and opcode 12 loads `pc` with P.
- R9: Opcode 0 (jump-and-store) writes the address of the following instruction into word X and sets `pc` to X+1. The accumulator is left unchanged.
- R10: Opcode 5 (input) loads the accumulator with the zero-extended `in_byte`. Opcode 6 (output) drives the low 8 accumulator bits onto `out_byte`.
- R11: Opcode 7 (halt) raises `halted`. After that, `pc` and `acc` never change until reset.
- R12: The step counter is one-hot at all times. A direct load takes 5 cycles and the halt instruction takes 3, so a load followed by a halt raises `halted` 8 cycles after reset is released.
- R13: Opcode 15 is a no-operation that changes nothing except `pc`, which advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program load write enable |
| prog_addr | input | 12 | Program load word address |
| prog_data | input | 16 | Program load word |
| in_byte | input | 8 | Input device value, sampled every cycle |
| out_byte | output | 8 | Output latch |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| halted | output | 1 | High once the halt instruction has executed |

## Verification
The properties assume that `prog_we` is used only while `rst` is high. A load-port write during execution could change the instruction being fetched, or the pointer being followed, between steps. The properties also assume that the step counter and the instruction latch hold meaningful values whenever reset is low. Every stimulus sequence therefore raises `rst` first, writes the program and its data words through the load port, and only then releases reset. `in_byte` is held steady for the whole of each run.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    OP_JNS    = 4'd0,
    OP_LOAD   = 4'd1,
    OP_STORE  = 4'd2,
    OP_ADD    = 4'd3,
    OP_SUBT   = 4'd4,
    OP_INPUT  = 4'd5,
    OP_OUTPUT = 4'd6,
    OP_HALT   = 4'd7,
    OP_SKIP   = 4'd8,
    OP_JUMP   = 4'd9,
    OP_CLEAR  = 4'd10,
    OP_ADDI   = 4'd11,
    OP_JUMPI  = 4'd12,
    OP_LOADI  = 4'd13,
    OP_STOREI = 4'd14,
    OP_NOP    = 4'd15
  } opcode_e;

  // bus location codes (source 0 = memory read, destination 0 = memory write)
  localparam logic [2:0] LOC_MEM = 3'd0;
  localparam logic [2:0] LOC_MAR = 3'd1;
  localparam logic [2:0] LOC_PC  = 3'd2;
  localparam logic [2:0] LOC_MBR = 3'd3;
  localparam logic [2:0] LOC_AC  = 3'd4;
  localparam logic [2:0] LOC_IN  = 3'd5;
  localparam logic [2:0] LOC_OUT = 3'd6;
  localparam logic [2:0] LOC_IR  = 3'd7;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_ZERO = 2'd3
  } alu_e;

  typedef struct packed {
    logic [2:0] src;
    logic [2:0] dst;
    alu_e       alu;
    logic       cr;      // return step counter to position 0
    logic       pc_inc;  // dedicated PC incrementer
    logic       ac2mbr;  // dedicated accumulator-to-MBR path
    logic       halt;
  } uop_t;

  function automatic uop_t mv(input logic [2:0] s, input logic [2:0] d);
    uop_t u;
    u     = '0;
    u.src = s;
    u.dst = d;
    return u;
  endfunction

  function automatic uop_t decode(input logic [3:0] op, input int st, input logic skip_hit);
    uop_t u;
    opcode_e oc;
    alu_e    fin;
    oc  = opcode_e'(op);
    fin = (oc == OP_ADD || oc == OP_ADDI) ? ALU_ADD :
          (oc == OP_SUBT) ? ALU_SUB : ALU_PASS;
    u   = '0;
    u.cr = 1'b1;
    if (st == 0) begin
      u = mv(LOC_PC, LOC_MAR);
    end else if (st == 1) begin
      u = mv(LOC_MEM, LOC_IR);
      u.pc_inc = 1'b1;
    end else begin
      case (oc)
        OP_LOAD, OP_ADD, OP_SUBT: begin
          case (st)
            2: u = mv(LOC_IR, LOC_MAR);
            3: u = mv(LOC_MEM, LOC_MBR);
            4: begin u = mv(LOC_MBR, LOC_AC); u.alu = fin; u.cr = 1'b1; end
            default: ;
          endcase
        end
        OP_STORE: begin
          case (st)
            2: begin u = mv(LOC_IR, LOC_MAR); u.ac2mbr = 1'b1; end
            3: begin u = mv(LOC_MBR, LOC_MEM); u.cr = 1'b1; end
            default: ;
          endcase
        end
        OP_ADDI, OP_LOADI, OP_JUMPI, OP_STOREI: begin
          case (st)
            2: u = mv(LOC_IR, LOC_MAR);
            3: u = mv(LOC_MEM, LOC_MBR);
            4: begin
              if (oc == OP_JUMPI) begin u = mv(LOC_MBR, LOC_PC); u.cr = 1'b1; end
              else u = mv(LOC_MBR, LOC_MAR);
            end
            5: begin
              if (oc == OP_STOREI) begin u = '0; u.ac2mbr = 1'b1; end
              else u = mv(LOC_MEM, LOC_MBR);
            end
            6: begin
              if (oc == OP_STOREI) u = mv(LOC_MBR, LOC_MEM);
              else begin u = mv(LOC_MBR, LOC_AC); u.alu = fin; end
              u.cr = 1'b1;
            end
            default: ;
          endcase
        end
        OP_JNS: begin
          case (st)
            2: u = mv(LOC_PC, LOC_MBR);
            3: u = mv(LOC_IR, LOC_MAR);
            4: u = mv(LOC_MBR, LOC_MEM);
            5: u = mv(LOC_MAR, LOC_PC);
            6: begin u = '0; u.pc_inc = 1'b1; u.cr = 1'b1; end
            default: ;
          endcase
        end
        OP_INPUT:  begin u = mv(LOC_IN, LOC_AC);  u.cr = 1'b1; end
        OP_OUTPUT: begin u = mv(LOC_AC, LOC_OUT); u.cr = 1'b1; end
        OP_HALT:   begin u = '0; u.halt = 1'b1; u.cr = 1'b1; end
        OP_SKIP:   begin u = '0; u.pc_inc = skip_hit; u.cr = 1'b1; end
        OP_JUMP:   begin u = mv(LOC_IR, LOC_PC); u.cr = 1'b1; end
        OP_CLEAR:  begin u = '0; u.alu = ALU_ZERO; u.cr = 1'b1; end
        default:   begin u = '0; u.cr = 1'b1; end
      endcase
    end
    return u;
  endfunction

endpackage

// File: rtl/acc_cpu_ring.sv
module acc_cpu_ring #(
  parameter int STEPS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clr,
  output logic [STEPS-1:0] step
);
  localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       step <= FIRST;
    else if (hold) step <= step;
    else if (clr)  step <= FIRST;
    else           step <= {step[STEPS-2:0], step[STEPS-1]};
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (op)
      ALU_PASS: y = b;
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int IOW   = 8,
  parameter int STEPS = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_we,
  input  logic [AW-1:0]  prog_addr,
  input  logic [DW-1:0]  prog_data,
  input  logic [IOW-1:0] in_byte,
  output logic [IOW-1:0] out_byte,
  output logic [DW-1:0]  acc,
  output logic [AW-1:0]  pc,
  output logic           halted
);
  localparam int OPW = 4;

  logic [STEPS-1:0] step;
  int               step_idx;
  uop_t             uop;
  logic [DW-1:0]    bus, mem_q, alu_y, mem_wdata;
  logic [AW-1:0]    mar_q, mar_nx, pc_q, mem_waddr;
  logic [DW-1:0]    ir_q, mbr_q, ac_q;
  logic [IOW-1:0]   inreg_q, outreg_q;
  logic             halted_q, active, xfer, skip_hit, mem_we;
  logic [1:0]       cond;

  always_comb begin
    step_idx = 0;
    for (int i = 0; i < STEPS; i++) if (step[i]) step_idx = i;
  end

  assign cond = ir_q[AW-1 -: 2];
  always_comb begin
    case (cond)
      2'b00:   skip_hit = ac_q[DW-1];
      2'b01:   skip_hit = (ac_q == '0);
      2'b10:   skip_hit = !ac_q[DW-1] && (ac_q != '0);
      default: skip_hit = 1'b0;
    endcase
  end

  assign uop    = decode(ir_q[DW-1 -: OPW], step_idx, skip_hit);
  assign active = !halted_q && !rst;
  assign xfer   = active && ({uop.src, uop.dst} != 6'd0);

  always_comb begin
    case (uop.src)
      LOC_MEM: bus = mem_q;
      LOC_MAR: bus = {{(DW-AW){1'b0}}, mar_q};
      LOC_PC:  bus = {{(DW-AW){1'b0}}, pc_q};
      LOC_MBR: bus = mbr_q;
      LOC_AC:  bus = ac_q;
      LOC_IN:  bus = {{(DW-IOW){1'b0}}, inreg_q};
      LOC_OUT: bus = {{(DW-IOW){1'b0}}, outreg_q};
      default: bus = ir_q;
    endcase
  end

  acc_cpu_ring #(.STEPS(STEPS)) ring_i (
    .clk(clk), .rst(rst), .hold(halted_q), .clr(uop.cr), .step(step)
  );

  acc_cpu_alu #(.DW(DW)) alu_i (.op(uop.alu), .a(ac_q), .b(bus), .y(alu_y));

  // read address is the next MAR so the registered read lines up with the step after
  assign mar_nx    = (xfer && uop.dst == LOC_MAR) ? bus[AW-1:0] : mar_q;
  assign mem_we    = prog_we || (xfer && uop.dst == LOC_MEM);
  assign mem_waddr = prog_we ? prog_addr : mar_q;
  assign mem_wdata = prog_we ? prog_data : bus;

  acc_cpu_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mar_nx), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q    <= '0;
      pc_q     <= '0;
      ir_q     <= '0;
      mbr_q    <= '0;
      ac_q     <= '0;
      inreg_q  <= '0;
      outreg_q <= '0;
      halted_q <= 1'b0;
    end else begin
      inreg_q <= in_byte;
      mar_q   <= mar_nx;
      if (active) begin
        if (xfer && uop.dst == LOC_PC) pc_q <= bus[AW-1:0];
        else if (uop.pc_inc)           pc_q <= pc_q + 1'b1;
        if (xfer && uop.dst == LOC_IR) ir_q <= bus;
        if (uop.ac2mbr)                     mbr_q <= ac_q;
        else if (xfer && uop.dst == LOC_MBR) mbr_q <= bus;
        if (uop.alu != ALU_PASS || (xfer && uop.dst == LOC_AC)) ac_q <= alu_y;
        if (xfer && uop.dst == LOC_OUT) outreg_q <= bus[IOW-1:0];
        if (uop.halt) halted_q <= 1'b1;
      end
    end
  end

  assign out_byte = outreg_q;
  assign acc      = ac_q;
  assign pc       = pc_q;
  assign halted   = halted_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int STEPS = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [STEPS-1:0] step,
  input logic [DW-1:0]    ir,
  input logic [AW-1:0]    pc,
  input logic [DW-1:0]    ac,
  input logic             halted
);
  p_step_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $countones(step) == 1);

  p_fetch_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step[1] && !halted) |=> (pc == $past(pc) + 1'b1));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (step[2] && !halted && ir[DW-1 -: 4] == 4'd10) |=> (ac == '0));

  p_skip_code3_r6: assert property (@(posedge clk) disable iff (rst)
    (step[2] && !halted && ir[DW-1 -: 4] == 4'd8 && ir[AW-1 -: 2] == 2'b11)
      |=> (pc == $past(pc)));

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (pc == $past(pc) && ac == $past(ac)));
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW), .STEPS(STEPS)) chk_i (
  .clk(clk), .rst(rst), .step(step), .ir(ir_q), .pc(pc_q), .ac(ac_q), .halted(halted_q)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [11:0] prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic [7:0]  in_byte = '0;
  logic [7:0]  out_byte;
  logic [15:0] acc;
  logic [11:0] pc;
  logic        halted;
  int          nchk = 0;
  int          nfail = 0;
  int          cyc;

  always #5 clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .in_byte(in_byte), .out_byte(out_byte),
    .acc(acc), .pc(pc), .halted(halted)
  );

  // vectors: operand A, operand B, subtract flag, expected result
  localparam logic [15:0] VA [6] = '{16'h0003, 16'h7FFF, 16'hFFFF, 16'h0005, 16'h8000, 16'h1234};
  localparam logic [15:0] VB [6] = '{16'h0004, 16'h0001, 16'h0001, 16'h0007, 16'h0001, 16'h1234};
  localparam logic        VS [6] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [15:0] VE [6] = '{16'h0007, 16'h8000, 16'h0000, 16'hFFFE, 16'h7FFF, 16'h0000};

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    prog_we = 1'b1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic run();
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic skip_case(input logic [15:0] v, input logic [1:0] code, input logic hit);
    hold_reset();
    put(12'h010, v);
    put(12'h000, ins(4'd1, 12'h010));
    put(12'h001, {4'd8, code, 10'd0});
    put(12'h002, ins(4'd7, 12'h000));
    put(12'h003, ins(4'd7, 12'h000));
    run();
    chk("R6", $sformatf("skip ac=%h code=%0d pc", v, code), pc, hit ? 12'd4 : 12'd3);
  endtask

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", pc, 0);
    chk("R1", "acc in reset", acc, 0);
    chk("R1", "halted in reset", halted, 0);
    chk("R1", "out in reset", out_byte, 0);

    // R3 R4 vector walk: load, add/sub, store, clear, reload, halt
    for (int k = 0; k < 6; k++) begin
      hold_reset();
      put(12'h010, VA[k]);
      put(12'h011, VB[k]);
      put(12'h000, ins(4'd1, 12'h010));
      put(12'h001, ins(VS[k] ? 4'd4 : 4'd3, 12'h011));
      put(12'h002, ins(4'd2, 12'h012));
      put(12'h003, ins(4'd10, 12'h000));
      put(12'h004, ins(4'd1, 12'h012));
      put(12'h005, ins(4'd7, 12'h000));
      run();
      chk("R4", $sformatf("vector %0d arithmetic via R3 store/load", k), acc, VE[k]);
    end

    // R12 timing and R2 fetch
    hold_reset();
    put(12'h010, 16'h0042);
    put(12'h000, ins(4'd1, 12'h010));
    put(12'h001, ins(4'd7, 12'h000));
    run();
    chk("R12", "cycles to halted", cyc, 8);
    chk("R3", "load value", acc, 16'h0042);
    chk("R2", "pc after halt fetch", pc, 12'd2);
    repeat (20) @(negedge clk);
    chk("R11", "halted stays", halted, 1);
    chk("R11", "pc frozen", pc, 12'd2);
    chk("R11", "acc frozen", acc, 16'h0042);

    // R5 clear
    hold_reset();
    put(12'h010, 16'h9ABC);
    put(12'h000, ins(4'd1, 12'h010));
    put(12'h001, ins(4'd10, 12'h000));
    put(12'h002, ins(4'd7, 12'h000));
    run();
    chk("R5", "clear", acc, 0);

    // R13 no-op
    hold_reset();
    put(12'h010, 16'h0042);
    put(12'h000, ins(4'd1, 12'h010));
    put(12'h001, 16'hF123);
    put(12'h002, ins(4'd7, 12'h000));
    run();
    chk("R13", "nop keeps acc", acc, 16'h0042);
    chk("R13", "nop pc", pc, 12'd3);

    // R6 skip conditions
    skip_case(16'hFFFF, 2'd0, 1'b1);
    skip_case(16'h0005, 2'd0, 1'b0);
    skip_case(16'h0000, 2'd1, 1'b1);
    skip_case(16'h0005, 2'd1, 1'b0);
    skip_case(16'h0005, 2'd2, 1'b1);
    skip_case(16'h0000, 2'd2, 1'b0);
    skip_case(16'hFFFF, 2'd3, 1'b0);
    skip_case(16'h0000, 2'd3, 1'b0);

    // R7 jump
    hold_reset();
    put(12'h000, ins(4'd9, 12'h040));
    put(12'h001, ins(4'd7, 12'h000));
    put(12'h040, ins(4'd7, 12'h000));
    run();
    chk("R7", "jump target", pc, 12'h041);

    // R8 indirect forms
    hold_reset();
    put(12'h050, 16'h0060);
    put(12'h060, ins(4'd7, 12'h000));
    put(12'h000, ins(4'd12, 12'h050));
    run();
    chk("R8", "jumpi target", pc, 12'h061);

    hold_reset();
    put(12'h050, 16'h0070);
    put(12'h070, 16'h1234);
    put(12'h061, 16'h0005);
    put(12'h000, ins(4'd13, 12'h050));
    put(12'h001, ins(4'd7, 12'h000));
    run();
    chk("R8", "loadi", acc, 16'h1234);

    hold_reset();
    put(12'h000, ins(4'd1, 12'h061));
    put(12'h001, ins(4'd11, 12'h050));
    put(12'h002, ins(4'd7, 12'h000));
    run();
    chk("R8", "addi", acc, 16'h1239);

    hold_reset();
    put(12'h062, 16'hBEEF);
    put(12'h051, 16'h0080);
    put(12'h000, ins(4'd1, 12'h062));
    put(12'h001, ins(4'd14, 12'h051));
    put(12'h002, ins(4'd10, 12'h000));
    put(12'h003, ins(4'd1, 12'h080));
    put(12'h004, ins(4'd7, 12'h000));
    run();
    chk("R8", "storei then reload", acc, 16'hBEEF);

    // R9 jump-and-store
    hold_reset();
    put(12'h030, 16'h55AA);
    put(12'h000, ins(4'd1, 12'h030));
    put(12'h001, ins(4'd0, 12'h020));
    put(12'h021, ins(4'd7, 12'h000));
    run();
    chk("R9", "jns pc", pc, 12'h022);
    chk("R9", "jns acc kept", acc, 16'h55AA);
    hold_reset();
    put(12'h000, ins(4'd1, 12'h020));
    put(12'h001, ins(4'd7, 12'h000));
    run();
    chk("R9", "jns return word", acc, 16'h0002);

    // R10 input and output
    hold_reset();
    in_byte = 8'hA5;
    put(12'h000, ins(4'd5, 12'h000));
    put(12'h001, ins(4'd7, 12'h000));
    run();
    chk("R10", "input zero-extended", acc, 16'h00A5);

    hold_reset();
    put(12'h010, 16'h1F3C);
    put(12'h000, ins(4'd1, 12'h010));
    put(12'h001, ins(4'd6, 12'h000));
    put(12'h002, ins(4'd7, 12'h000));
    run();
    chk("R10", "output low byte", out_byte, 8'h3C);

    // R1 reset after a halted run
    hold_reset();
    chk("R1", "halted cleared", halted, 0);
    chk("R1", "out cleared", out_byte, 0);
    chk("R1", "acc cleared", acc, 0);
    chk("R1", "pc cleared", pc, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule